// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial frames. The host writes a byte into a holding stage. When the line is free, the byte moves into a hidden shift stage. The holding stage is then open for the next byte, so one byte can wait while another is on the wire. Every frame has the same layout. A low start bit comes first. The data bits follow, least significant first. An optional parity bit comes next, and the frame closes with a high stop period of one, one and a half or two bit times.

Bit timing comes from `tick16`, a strobe at sixteen times the baud rate. An external divider, programmable from 1 to 65535, produces it. One bit lasts `OS` ticks. The parity setting and the stop-length setting are captured when a byte enters the shift stage, so changing them mid-frame affects only later frames. The controller has five states. In `S_IDLE` the line is high. `S_IDLE -> S_START` happens when a byte is waiting. `S_START -> S_DATA` happens after one bit time. `S_DATA` repeats for each data bit. From the last data bit it goes to `S_PARITY` if parity is enabled, otherwise to `S_STOP`. `S_PARITY -> S_STOP` happens after one bit time. `S_STOP` ends either in `S_START`, when a byte is waiting, or in `S_IDLE`.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1, and the line stays high while nothing is written.
- R2: A frame starts with `txd` low for exactly 16 ticks. Then the 8 data bits follow, least significant first, each held for 16 ticks.
- R3: With `par_cfg` = 3'b001 (bit0 enable, bit1 odd, bit2 stick) the bit after the data makes the count of ones even. With 3'b011 it makes the count odd.
- R4: With stick parity (`par_cfg` bit2 and bit0 set) the parity bit is the value of `par_cfg` bit1: 0 for 3'b101 and 1 for 3'b111, whatever the data.
- R5: With `par_cfg` bit0 clear there is no parity bit, and the stop period follows the last data bit directly.
- R6: The stop period is high and lasts 16 ticks for `stop_sel` 2'b00, 24 ticks for 2'b01, and 32 ticks for 2'b10 or 2'b11. `tx_empty` rises on the tick that ends it.
- R7: A write clears `hold_empty` on the next clock. `hold_empty` sets again on the clock where the shift stage loads. `tx_empty` is 1 only when both stages are empty.
- R8: If a byte is waiting when the stop period ends, its start bit begins on that same tick, with no idle time between frames.
- R9: A write while the holding stage is full replaces the waiting byte. Only the last byte written is sent.
- R10: Parity and stop settings are captured when the shift stage loads. Changes during a frame do not affect that frame.
- R11: While the frame is running, `txd` changes only on clocks where `tick16` is high. Withholding ticks freezes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe that writes `wr_data` into the holding stage |
| wr_data | input | DW | Byte to send |
| par_cfg | input | 3 | Parity: bit0 enable, bit1 odd, bit2 stick |
| stop_sel | input | 2 | Stop length: 00 one bit, 01 one and a half bits, 1x two bits |
| tick16 | input | 1 | Oversampling strobe, OS ticks per bit |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding stage can accept a byte |
| tx_empty | output | 1 | Both stages empty and line idle |

## Verification
A wrong state or a miscounted tick shows on `txd` within one bit time. It appears as a start or data edge that is off by one tick, or as a missing or extra parity slot. Sampling the line at the exact boundary ticks, not only mid-bit, catches off-by-one errors in the counter. Faults in the holding stage or in the load decision show on `hold_empty` one clock after a write or a load. Later they show at the frame boundary, as a gap, a lost byte or a stale byte in the following frame.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_sel_e;

    localparam int PAR_EN    = 0;
    localparam int PAR_ODD   = 1;
    localparam int PAR_STICK = 2;
endpackage

// File: rtl/utx_holdreg.sv
module utx_holdreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] q,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            full <= 1'b0;
        end else if (wr_en) begin
            q    <= wr_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R7: a write always leaves the stage full
    p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);
    // R7: a load without a concurrent write frees the stage
    p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);
    // R9: a write into a full stage replaces the stored byte
    p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (q == $past(wr_data)));
endmodule

// File: rtl/utx_tickcnt.sv
module utx_tickcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the count never passes the length chosen for the current slot
    p_cnt_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));
    // R11: without a tick the count holds
    p_cnt_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] din,
    input  logic [2:0]    par_cfg,
    output logic          lsb,
    output logic          par_bit,
    output logic          par_on
);
    logic [DW-1:0] sh;
    logic          par_calc;

    always_comb begin
        if (par_cfg[PAR_STICK]) begin
            par_calc = par_cfg[PAR_ODD];
        end else if (par_cfg[PAR_ODD]) begin
            par_calc = ~^din;
        end else begin
            par_calc = ^din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            par_bit <= 1'b0;
            par_on  <= 1'b0;
        end else if (load) begin
            sh      <= din;
            par_bit <= par_calc;
            par_on  <= par_cfg[PAR_EN];
        end else if (shift) begin
            sh <= sh >> 1;
        end
    end

    assign lsb = sh[0];

    // R10: the shift stage takes the waiting byte on a load
    p_load_copies_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh == $past(din)));
    // R10: captured parity settings stay fixed between loads
    p_par_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(par_on) && $stable(par_bit));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import utx_pkg::*;
#(
    parameter int DW = 8,
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    par_cfg,
    input  logic [1:0]    stop_sel,
    input  logic          tick16,
    output logic          txd,
    output logic          hold_empty,
    output logic          tx_empty
);
    localparam int CW = $clog2(2 * OS + 1);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     state, nstate;
    stop_sel_e     stop_q;
    logic [BW-1:0] bidx;
    logic [DW-1:0] hold_q;
    logic [CW-1:0] limit;
    logic          hold_full, load, done, shift, run;
    logic          sh_lsb, par_bit, par_on;

    utx_holdreg #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .q       (hold_q),
        .full    (hold_full)
    );

    utx_tickcnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick16),
        .limit (limit),
        .done  (done)
    );

    utx_shifter #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .din     (hold_q),
        .par_cfg (par_cfg),
        .lsb     (sh_lsb),
        .par_bit (par_bit),
        .par_on  (par_on)
    );

    assign run   = (state != S_IDLE);
    assign load  = hold_full && ((state == S_IDLE) || ((state == S_STOP) && done));
    assign shift = (state == S_DATA) && done;

    always_comb begin
        limit = CW'(OS);
        if (state == S_STOP) begin
            unique case (stop_q)
                STOP_ONE:      limit = CW'(OS);
                STOP_ONE_HALF: limit = CW'(OS + OS / 2);
                STOP_TWO:      limit = CW'(2 * OS);
                STOP_TWO_ALT:  limit = CW'(2 * OS);
            endcase
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (hold_full) nstate = S_START;
            S_START:  if (done) nstate = S_DATA;
            S_DATA:   if (done && (bidx == BW'(DW - 1))) nstate = par_on ? S_PARITY : S_STOP;
            S_PARITY: if (done) nstate = S_STOP;
            S_STOP:   if (done) nstate = hold_full ? S_START : S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            stop_q <= STOP_ONE;
            bidx   <= '0;
        end else begin
            state <= nstate;
            if (load) stop_q <= stop_sel_e'(stop_sel);
            if (state == S_START && done) bidx <= '0;
            else if (shift) bidx <= bidx + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:   txd = 1'b1;
            S_START:  txd = 1'b0;
            S_DATA:   txd = sh_lsb;
            S_PARITY: txd = par_bit;
            S_STOP:   txd = 1'b1;
            default:  txd = 1'b1;
        endcase
        hold_empty = !hold_full;
        tx_empty   = (state == S_IDLE) && !hold_full;
    end

    // R7: the transmitter never reports empty while a byte waits
    p_empty_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);
    // R11: once a frame runs, the line moves only on a tick
    p_line_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) != S_IDLE) && (txd != $past(txd))) |-> $past(tick16));
    // R8: a waiting byte starts right where the stop period ends
    p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && done && hold_full) |=> (state == S_START) && !txd);
    // R1: an idle transmitter with nothing queued holds the line high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !wr_en) |=> txd);
endmodule

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int OS         = 16;
    localparam int TDIV       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] par_cfg = 3'b000;
    logic [1:0] stop_sel = 2'b00;
    logic       tick16 = 1'b0;
    logic       txd, hold_empty, tx_empty;

    uart_tx_framer #(.DW(8), .OS(OS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .par_cfg    (par_cfg),
        .stop_sel   (stop_sel),
        .tick16     (tick16),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int   n_run = 0;
    int   n_fail = 0;
    logic rec_line [0:1023];
    logic rec_hold [0:1023];
    logic rec_emp  [0:1023];
    int   j = 0;
    int   div = 0;
    bit   mon_on = 1'b0;
    bit   mon_act = 1'b0;
    bit   tick_q = 1'b0;
    bit   stall = 1'b0;

    // tick source and line recorder: index j counts ticks since the start edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (!mon_act) begin
                if (txd == 1'b0) begin
                    mon_act = 1'b1;
                    j = 0;
                end
            end else if (tick_q && j < 1023) begin
                j = j + 1;
                rec_line[j] = txd;
                rec_hold[j] = hold_empty;
                rec_emp[j]  = tx_empty;
            end
        end else begin
            mon_act = 1'b0;
            j = 0;
        end
        div    = (div == TDIV - 1) ? 0 : div + 1;
        tick16 = (div == 0) && !stall;
        tick_q = tick16;
    end

    task automatic chk(string req, logic act, logic exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic int stop_ticks(logic [1:0] ss);
        if (ss == 2'b00) return OS;
        if (ss == 2'b01) return OS + OS / 2;
        return 2 * OS;
    endfunction

    function automatic int flen(logic [2:0] pc, logic [1:0] ss);
        return OS * (9 + (pc[0] ? 1 : 0)) + stop_ticks(ss);
    endfunction

    function automatic logic par_of(logic [7:0] d, logic [2:0] pc);
        if (pc[2]) return pc[1];
        return pc[1] ? ~^d : ^d;
    endfunction

    task automatic wait_j(int n);
        while (j < n) @(negedge clk);
    endtask

    task automatic verify(string preq, int base, logic [7:0] d, logic [2:0] pc, logic [1:0] ss);
        int L;
        L = flen(pc, ss);
        chk("R2", rec_line[base + OS - 1], 1'b0, "start bit last tick");
        chk("R2", rec_line[base + OS], d[0], "first data bit edge");
        for (int b = 1; b <= 8; b++)
            chk("R2", rec_line[base + OS * b + OS / 2], d[b-1], $sformatf("data bit %0d", b - 1));
        chk(preq, rec_line[base + OS * 9 + OS / 2], pc[0] ? par_of(d, pc) : 1'b1, "slot after data");
        chk("R6", rec_line[base + L - 1], 1'b1, "stop last tick");
    endtask

    task automatic send(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mon_start();
        @(posedge clk);
        mon_on = 1'b1;
    endtask

    task automatic mon_stop();
        @(posedge clk);
        mon_on = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", txd, 1'b1, "line after reset");
        chk("R1", hold_empty, 1'b1, "hold flag after reset");
        chk("R1", tx_empty, 1'b1, "empty flag after reset");
        repeat (40) @(negedge clk);
        chk("R1", txd, 1'b1, "line idle with ticks");
    endtask

    task automatic run_single(string preq, logic [7:0] d, logic [2:0] pc, logic [1:0] ss);
        int L;
        L = flen(pc, ss);
        par_cfg = pc;
        stop_sel = ss;
        mon_start();
        send(d);
        chk("R7", hold_empty, 1'b0, "hold flag after write");
        chk("R7", tx_empty, 1'b0, "empty flag after write");
        @(negedge clk);
        chk("R7", hold_empty, 1'b1, "hold flag after load");
        chk("R7", tx_empty, 1'b0, "empty flag while sending");
        chk("R2", txd, 1'b0, "start edge on load");
        wait_j(L + 1);
        verify(preq, 0, d, pc, ss);
        chk("R6", rec_emp[L-1], 1'b0, "empty before stop end");
        chk("R6", rec_emp[L], 1'b1, "empty at stop end");
        mon_stop();
    endtask

    task automatic t_back_to_back();
        int L1;
        par_cfg = 3'b000;
        stop_sel = 2'b01;
        L1 = flen(3'b000, 2'b01);
        mon_start();
        send(8'h3C);
        @(negedge clk);
        send(8'hC5);
        wait_j(2 * L1 + 1);
        verify("R5", 0, 8'h3C, 3'b000, 2'b01);
        chk("R8", rec_line[L1-1], 1'b1, "stop before queued frame");
        chk("R8", rec_line[L1], 1'b0, "queued start edge");
        chk("R7", rec_hold[L1-1], 1'b0, "hold full before second load");
        chk("R7", rec_hold[L1], 1'b1, "hold empty at second load");
        chk("R7", rec_emp[L1], 1'b0, "not empty at second load");
        verify("R8", L1, 8'hC5, 3'b000, 2'b01);
        chk("R6", rec_emp[2 * L1], 1'b1, "empty after second frame");
        mon_stop();
    endtask

    task automatic t_overwrite();
        int L1;
        par_cfg = 3'b000;
        stop_sel = 2'b00;
        L1 = flen(3'b000, 2'b00);
        mon_start();
        send(8'h81);
        send(8'h5A);
        send(8'hE7);
        wait_j(2 * L1 + 1);
        verify("R9", 0, 8'h81, 3'b000, 2'b00);
        chk("R9", rec_line[L1], 1'b0, "second frame start");
        verify("R9", L1, 8'hE7, 3'b000, 2'b00);
        chk("R9", rec_emp[2 * L1], 1'b1, "no third frame");
        mon_stop();
    endtask

    task automatic t_cfg_latch();
        int L;
        par_cfg = 3'b001;
        stop_sel = 2'b00;
        L = flen(3'b001, 2'b00);
        mon_start();
        send(8'h07);
        @(negedge clk);
        par_cfg = 3'b111;
        stop_sel = 2'b10;
        wait_j(L + 1);
        verify("R10", 0, 8'h07, 3'b001, 2'b00);
        chk("R10", rec_emp[L], 1'b1, "stop length from load time");
        mon_stop();
        par_cfg = 3'b000;
        stop_sel = 2'b00;
    endtask

    task automatic t_stall();
        int L;
        int jh;
        logic lv;
        par_cfg = 3'b000;
        stop_sel = 2'b00;
        L = flen(3'b000, 2'b00);
        mon_start();
        send(8'h96);
        wait_j(OS + OS / 2);
        @(posedge clk);
        stall = 1'b1;
        @(negedge clk);
        @(negedge clk);
        lv = txd;
        jh = j;
        repeat (40) @(negedge clk);
        chk("R11", txd, lv, "line frozen without ticks");
        chk("R11", (j == jh) ? 1'b1 : 1'b0, 1'b1, "no ticks counted");
        chk("R11", tx_empty, 1'b0, "frame still open");
        @(posedge clk);
        stall = 1'b0;
        wait_j(L + 1);
        verify("R11", 0, 8'h96, 3'b000, 2'b00);
        mon_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all: actual not finished expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_single("R5", 8'h4B, 3'b000, 2'b00);
        run_single("R3", 8'h4B, 3'b001, 2'b00);
        run_single("R3", 8'h4B, 3'b011, 2'b00);
        run_single("R3", 8'h07, 3'b001, 2'b00);
        run_single("R4", 8'h07, 3'b101, 2'b00);
        run_single("R4", 8'h4B, 3'b111, 2'b00);
        run_single("R6", 8'hF0, 3'b000, 2'b01);
        run_single("R6", 8'h0F, 3'b011, 2'b10);
        run_single("R6", 8'hAA, 3'b000, 2'b11);
        t_back_to_back();
        t_overwrite();
        t_cfg_latch();
        t_stall();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule